// File: doc/BRIEF.md
# Shared-Memory Network Interrupt Controller

This block sits between the replicated-memory logic of a ring network node and its host. For every host write that leaves the node it decides whether the outgoing message carries the interrupt flag. For every message arriving from the ring it decides whether the updated memory address must be reported to the host. Reported addresses go into a first-in first-out queue. The host drains that queue through two 16-bit registers: one holds the low address half, the other holds the upper bits and the status.

The decisions use the per-longword auxiliary control bits that come with each access: a transmit-enable bit and a receive-enable bit. They also use node-wide enable and override bits. A self-originated message is only considered when both own-message enables are set. Error sources are caught in a latched error register that clears when read. A mask register selects which latched errors may interrupt the host. An overflowing address queue is one of those error sources.

A small state machine drives the host request. In `ST_ARMED` the request is low and the machine waits for a cause. A cause is a non-empty queue, or an unmasked latched error while error interrupts are enabled. `ARM_RAISE` moves the machine to `ST_RAISED` on the clock edge after a cause appears, and the request is high in that state. When the cause goes away, `RAISE_DONE` moves it to `ST_SPENT`. There the request stays low even if a new cause arrives. A host write to the error register takes `SPENT_REARM` back to `ST_ARMED`.

Top module: `smn_irq_top`

## Requirements
- R1: The outgoing interrupt flag `tx_msg_int_o` is 1 only when `tx_wr_i` is 1, `net_int_en_i` is 1, and either `tx_int_ovr_i` or the word's `tx_tie_i` is 1. It is 0 for all other input combinations.
- R2: A received message from another node is queued only when its INT bit `rx_int_i` is 1 and either `rx_int_ovr_i` is 1 or both `rx_rie_i` and `mask_match_en_i` are 1. A message with INT 0 is never queued.
- R3: A message with `rx_native_i` = 1 is queued only when `own_wr_en_i` and `own_int_en_i` are both 1, in addition to the conditions of R2.
- R4: Register select 0 reads `{addr[15:2], 2'b00}` of the oldest entry. Register select 1 reads bit 15 = queue not empty, bit 14 = retry flag of the oldest entry, bits 13:7 = 0, and bits 6:0 = addr[22:16]. A read strobe on select 0 removes the oldest entry. Entries leave in arrival order.
- R5: When the queue is empty, selects 0 and 1 read 0. A read strobe on select 0 then changes nothing.
- R6: The queue holds `DEPTH` entries. A queueing event while the queue is full and not being read is dropped and sets error bit 0. The earlier entries are kept unchanged.
- R7: A 1 on bit i of `err_src_i` sets error bit i, which holds until read at select 2. That read returns the latched bits and clears them. A source asserted during the read cycle stays set.
- R8: A latched error is a cause only when `err_int_en_i` is 1 and the matching bit of the mask register (select 3, `ERR_W` bits, upper bits read 0, reset 0) is 1.
- R9: `irq_o` rises one cycle after a cause appears in `ST_ARMED`. It stays high while the cause lasts and falls one cycle after the cause ends. It then stays low despite new causes until any value is written to select 2, after which a present cause raises it again one cycle later.
- R10: After reset `irq_o` is 0, the queue is empty, and the error and mask registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_int_en_i | input | 1 | Node-wide enable for sending interrupt messages |
| tx_int_ovr_i | input | 1 | Send every host write as an interrupt message |
| mask_match_en_i | input | 1 | Honour per-word receive-enable bits |
| rx_int_ovr_i | input | 1 | Queue every interrupt message regardless of the word bit |
| own_wr_en_i | input | 1 | Accept own messages back into memory |
| own_int_en_i | input | 1 | Allow own messages to interrupt |
| err_int_en_i | input | 1 | Allow latched errors to interrupt |
| tx_wr_i | input | 1 | Host write leaving on the ring this cycle |
| tx_tie_i | input | 1 | Transmit-interrupt control bit of the written word |
| tx_msg_int_o | output | 1 | Interrupt flag for the outgoing message |
| rx_valid_i | input | 1 | Received message present this cycle |
| rx_int_i | input | 1 | INT bit of the received message |
| rx_native_i | input | 1 | Received message was sent by this node |
| rx_rie_i | input | 1 | Receive-interrupt control bit of the addressed word |
| rx_retry_i | input | 1 | Retry flag stored with the queued address |
| rx_addr_i | input | 23 | Longword byte address of the received message |
| err_src_i | input | ERR_W | Error condition pulses |
| reg_sel_i | input | 2 | Host register select |
| reg_rd_i | input | 1 | Host read strobe |
| reg_wr_i | input | 1 | Host write strobe |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Host read data for the selected register |
| irq_o | output | 1 | Host interrupt request |

## Verification
The hardest situation to reach is `ST_SPENT` with a fresh cause pending. In that state the request must stay low, and it must come back only after a re-arm write. To get there, the bench raises the request with an error, clears the error by reading it, waits out the fall, and then queues a new message. It checks that the request stays low for several cycles before it writes the re-arm value. The qualification logic is swept over every combination of its seven message and enable inputs. The queue is filled past its depth in a small configuration so that the drop and its error bit can be seen.

// File: rtl/smn_irq_pkg.sv
package smn_irq_pkg;
    localparam int ADDR_W = 23;
    localparam int REG_W  = 16;

    typedef struct packed {
        logic              retry;
        logic [ADDR_W-1:0] addr;
    } irq_entry_t;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_RAISED = 2'd1,
        ST_SPENT  = 2'd2
    } arm_state_t;

    localparam logic [1:0] SEL_ADDR_LO = 2'd0;
    localparam logic [1:0] SEL_ADDR_HI = 2'd1;
    localparam logic [1:0] SEL_ERR     = 2'd2;
    localparam logic [1:0] SEL_MASK    = 2'd3;
endpackage

// File: rtl/smn_irq_qual.sv
module smn_irq_qual (
    input  logic tx_wr_i,
    input  logic net_int_en_i,
    input  logic tx_int_ovr_i,
    input  logic tx_tie_i,
    input  logic rx_valid_i,
    input  logic rx_int_i,
    input  logic rx_native_i,
    input  logic rx_rie_i,
    input  logic mask_match_en_i,
    input  logic rx_int_ovr_i,
    input  logic own_wr_en_i,
    input  logic own_int_en_i,
    output logic tx_msg_int_o,
    output logic rx_push_o
);
    logic tx_word_wants;
    logic rx_candidate;
    logic own_allowed;
    logic rx_word_wants;

    always_comb begin
        tx_word_wants = tx_int_ovr_i | tx_tie_i;
        tx_msg_int_o  = tx_wr_i & net_int_en_i & tx_word_wants;
    end

    always_comb begin
        own_allowed   = own_wr_en_i & own_int_en_i;
        rx_candidate  = rx_valid_i & rx_int_i & (~rx_native_i | own_allowed);
        rx_word_wants = rx_int_ovr_i | (rx_rie_i & mask_match_en_i);
        rx_push_o     = rx_candidate & rx_word_wants;
    end
endmodule

// File: rtl/smn_irq_fifo.sv
module smn_irq_fifo
    import smn_irq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  irq_entry_t entry_i,
    input  logic       pop_i,
    output irq_entry_t head_o,
    output logic       not_empty_o,
    output logic       drop_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    irq_entry_t       mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             full;
    logic             pop_ok;
    logic             push_ok;

    always_comb begin
        full        = (count_q == FULL_CNT);
        not_empty_o = (count_q != '0);
        pop_ok      = pop_i & not_empty_o;
        push_ok     = push_i & (~full | pop_ok);
        drop_o      = push_i & ~push_ok;
        head_o      = mem_q[rd_ptr_q];
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[wr_ptr_q] <= entry_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr_q <= (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr_q <= (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_CNT);

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !not_empty_o && !push_i) |=> !not_empty_o);
endmodule

// File: rtl/smn_irq_errlat.sv
module smn_irq_errlat #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] set_i,
    input  logic             clr_i,
    input  logic             mask_wr_i,
    input  logic [ERR_W-1:0] mask_wdata_i,
    input  logic             err_int_en_i,
    output logic [ERR_W-1:0] err_o,
    output logic [ERR_W-1:0] mask_o,
    output logic             err_cause_o
);
    logic [ERR_W-1:0] err_q;
    logic [ERR_W-1:0] mask_q;
    logic [ERR_W-1:0] kept;

    always_comb begin
        kept        = clr_i ? '0 : err_q;
        err_o       = err_q;
        mask_o      = mask_q;
        err_cause_o = err_int_en_i & (|(err_q & mask_q));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= '0;
            mask_q <= '0;
        end else begin
            err_q <= kept | set_i;
            if (mask_wr_i) begin
                mask_q <= mask_wdata_i;
            end
        end
    end

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((err_q & $past(err_q)) == $past(err_q)));

    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((err_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/smn_irq_arm.sv
module smn_irq_arm
    import smn_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cause_i,
    input  logic rearm_i,
    output logic irq_o
);
    arm_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:  state_d = cause_i ? ST_RAISED : ST_ARMED;
            ST_RAISED: state_d = cause_i ? ST_RAISED : ST_SPENT;
            ST_SPENT:  state_d = rearm_i ? ST_ARMED  : ST_SPENT;
            default:   state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        irq_o = (state_q == ST_RAISED);
    end

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(cause_i));

    // R9
    spent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !rearm_i && $past(!irq_o && !rearm_i) && $past(irq_o, 2))
        |=> !irq_o);
endmodule

// File: rtl/smn_irq_top.sv
module smn_irq_top
    import smn_irq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int ERR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              net_int_en_i,
    input  logic              tx_int_ovr_i,
    input  logic              mask_match_en_i,
    input  logic              rx_int_ovr_i,
    input  logic              own_wr_en_i,
    input  logic              own_int_en_i,
    input  logic              err_int_en_i,
    input  logic              tx_wr_i,
    input  logic              tx_tie_i,
    output logic              tx_msg_int_o,
    input  logic              rx_valid_i,
    input  logic              rx_int_i,
    input  logic              rx_native_i,
    input  logic              rx_rie_i,
    input  logic              rx_retry_i,
    input  logic [22:0]       rx_addr_i,
    input  logic [ERR_W-1:0]  err_src_i,
    input  logic [1:0]        reg_sel_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    output logic              irq_o
);
    localparam int HI_PAD = REG_W - 9;

    logic             rx_push;
    irq_entry_t       new_entry;
    irq_entry_t       head;
    logic             not_empty;
    logic             drop;
    logic             pop_req;
    logic             err_clr;
    logic             rearm;
    logic             mask_wr;
    logic [ERR_W-1:0] err_set;
    logic [ERR_W-1:0] err_val;
    logic [ERR_W-1:0] mask_val;
    logic             err_cause;
    logic             cause;
    logic             unused_bits;

    smn_irq_qual i_qual (
        .tx_wr_i         (tx_wr_i),
        .net_int_en_i    (net_int_en_i),
        .tx_int_ovr_i    (tx_int_ovr_i),
        .tx_tie_i        (tx_tie_i),
        .rx_valid_i      (rx_valid_i),
        .rx_int_i        (rx_int_i),
        .rx_native_i     (rx_native_i),
        .rx_rie_i        (rx_rie_i),
        .mask_match_en_i (mask_match_en_i),
        .rx_int_ovr_i    (rx_int_ovr_i),
        .own_wr_en_i     (own_wr_en_i),
        .own_int_en_i    (own_int_en_i),
        .tx_msg_int_o    (tx_msg_int_o),
        .rx_push_o       (rx_push)
    );

    always_comb begin
        new_entry.retry = rx_retry_i;
        new_entry.addr  = rx_addr_i;
        pop_req = reg_rd_i & (reg_sel_i == SEL_ADDR_LO);
        err_clr = reg_rd_i & (reg_sel_i == SEL_ERR);
        rearm   = reg_wr_i & (reg_sel_i == SEL_ERR);
        mask_wr = reg_wr_i & (reg_sel_i == SEL_MASK);
        err_set = err_src_i | {{(ERR_W-1){1'b0}}, drop};
        cause   = not_empty | err_cause;
    end

    smn_irq_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (rx_push),
        .entry_i     (new_entry),
        .pop_i       (pop_req),
        .head_o      (head),
        .not_empty_o (not_empty),
        .drop_o      (drop)
    );

    smn_irq_errlat #(.ERR_W(ERR_W)) i_errlat (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (err_set),
        .clr_i        (err_clr),
        .mask_wr_i    (mask_wr),
        .mask_wdata_i (reg_wdata_i[ERR_W-1:0]),
        .err_int_en_i (err_int_en_i),
        .err_o        (err_val),
        .mask_o       (mask_val),
        .err_cause_o  (err_cause)
    );

    smn_irq_arm i_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause),
        .rearm_i (rearm),
        .irq_o   (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_sel_i)
            SEL_ADDR_LO: if (not_empty) reg_rdata_o = {head.addr[15:2], 2'b00};
            SEL_ADDR_HI: if (not_empty) reg_rdata_o = {1'b1, head.retry, {HI_PAD{1'b0}}, head.addr[22:16]};
            SEL_ERR:     reg_rdata_o = REG_W'(err_val);
            SEL_MASK:    reg_rdata_o = REG_W'(mask_val);
            default:     reg_rdata_o = '0;
        endcase
    end

    assign unused_bits = ^{reg_wdata_i, head.addr[1:0]};

    // R1
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_msg_int_o |-> (tx_wr_i && net_int_en_i));

    // R2
    no_int_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !rx_int_i) |-> !rx_push);

    // R3
    own_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_native_i && !(own_wr_en_i && own_int_en_i)) |-> !rx_push);

    // R6
    drop_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> err_val[0]);
endmodule

// File: tb/test_smn_irq_top.sv
`timescale 1ns/1ps
module test_smn_irq_top;
    localparam int DEPTH = 4;
    localparam int ERR_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic net_int_en = 0, tx_int_ovr = 0, mask_match_en = 0, rx_int_ovr = 0;
    logic own_wr_en = 0, own_int_en = 0, err_int_en = 0;
    logic tx_wr = 0, tx_tie = 0, tx_msg_int;
    logic rx_valid = 0, rx_int = 0, rx_native = 0, rx_rie = 0, rx_retry = 0;
    logic [22:0] rx_addr = '0;
    logic [ERR_W-1:0] err_src = '0;
    logic [1:0] reg_sel = '0;
    logic reg_rd = 0, reg_wr = 0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    smn_irq_top #(.DEPTH(DEPTH), .ERR_W(ERR_W)) i_smn_irq_top (
        .clk(clk), .rst_n(rst_n),
        .net_int_en_i(net_int_en), .tx_int_ovr_i(tx_int_ovr),
        .mask_match_en_i(mask_match_en), .rx_int_ovr_i(rx_int_ovr),
        .own_wr_en_i(own_wr_en), .own_int_en_i(own_int_en),
        .err_int_en_i(err_int_en),
        .tx_wr_i(tx_wr), .tx_tie_i(tx_tie), .tx_msg_int_o(tx_msg_int),
        .rx_valid_i(rx_valid), .rx_int_i(rx_int), .rx_native_i(rx_native),
        .rx_rie_i(rx_rie), .rx_retry_i(rx_retry), .rx_addr_i(rx_addr),
        .err_src_i(err_src),
        .reg_sel_i(reg_sel), .reg_rd_i(reg_rd), .reg_wr_i(reg_wr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] sel, output logic [15:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [15:0] v);
        reg_sel = sel;
        reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [15:0] d);
        reg_sel = sel;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic send(input logic [22:0] a, input logic rt, input logic ib,
                        input logic nat, input logic rie);
        rx_addr = a; rx_retry = rt; rx_int = ib; rx_native = nat; rx_rie = rie;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pulse_err(input logic [ERR_W-1:0] p);
        err_src = p;
        @(negedge clk);
        err_src = '0;
    endtask

    function automatic logic [15:0] hi_word(input logic [22:0] a, input logic rt);
        return {1'b1, rt, 7'b0, a[22:16]};
    endfunction

    function automatic logic [15:0] lo_word(input logic [22:0] a);
        return {a[15:2], 2'b00};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [22:0] exp_a [8];
        logic        exp_r [8];

        do_reset();

        // R10 reset state
        chk("R10 irq", 32'(irq), 0);
        peek(2'd0, v); chk("R10 lo", 32'(v), 0);
        peek(2'd1, v); chk("R10 hi", 32'(v), 0);
        peek(2'd2, v); chk("R10 err", 32'(v), 0);
        peek(2'd3, v); chk("R10 mask", 32'(v), 0);

        // R1 exhaustive transmit gate
        for (int t = 0; t < 16; t++) begin
            tx_wr = t[0]; net_int_en = t[1]; tx_int_ovr = t[2]; tx_tie = t[3];
            #1 chk("R1 tx flag", 32'(tx_msg_int),
                   32'(t[0] & t[1] & (t[2] | t[3])));
        end
        tx_wr = 0; net_int_en = 0; tx_int_ovr = 0; tx_tie = 0;
        @(negedge clk);

        // R2 / R3 exhaustive receive qualification
        for (int s = 0; s < 128; s++) begin
            logic [22:0] a;
            logic ib, nat, rie, exp_push;
            ib = s[0]; nat = s[1]; rie = s[2];
            mask_match_en = s[3]; rx_int_ovr = s[4]; own_wr_en = s[5]; own_int_en = s[6];
            a = 23'((s * 70001 + 4099) & 32'h7FFFFF);
            exp_push = ib & (~nat | (s[5] & s[6])) & (s[4] | (s[2] & s[3]));
            send(a, s[0] ^ s[3], ib, nat, rie);
            peek(2'd1, v);
            if (exp_push) begin
                chk(nat ? "R3 own hi" : "R2 foreign hi", 32'(v), 32'(hi_word(a, s[0] ^ s[3])));
                rd_reg(2'd0, v);
                chk(nat ? "R3 own lo" : "R2 foreign lo", 32'(v), 32'(lo_word(a)));
            end else begin
                chk(nat ? "R3 own blocked" : "R2 foreign blocked", 32'(v[15]), 0);
            end
        end
        mask_match_en = 0; rx_int_ovr = 0; own_wr_en = 0; own_int_en = 0;

        // R4 / R6 fill past depth, order, drop
        do_reset();
        mask_match_en = 1;
        for (int k = 0; k <= DEPTH; k++) begin
            exp_a[k] = 23'((k * 32'h0ACE5 + 32'h12345) & 32'h7FFFFF);
            exp_r[k] = k[0];
            send(exp_a[k], exp_r[k], 1'b1, 1'b0, 1'b1);
        end
        peek(2'd2, v); chk("R6 full error bit", 32'(v), 1);
        for (int k = 0; k < DEPTH; k++) begin
            peek(2'd1, v); chk("R4 hi order", 32'(v), 32'(hi_word(exp_a[k], exp_r[k])));
            rd_reg(2'd0, v); chk("R4 lo order", 32'(v), 32'(lo_word(exp_a[k])));
        end
        // R5 empty reads
        peek(2'd1, v); chk("R5 hi empty", 32'(v), 0);
        rd_reg(2'd0, v); chk("R5 lo empty", 32'(v), 0);
        peek(2'd1, v); chk("R5 empty pop no effect", 32'(v), 0);
        mask_match_en = 0;

        // R7 latch / clear on read
        do_reset();
        for (int p = 1; p < 16; p++) begin
            pulse_err(ERR_W'(p));
            step(1);
            peek(2'd2, v); chk("R7 latched held", 32'(v), 32'(p));
            rd_reg(2'd2, v); chk("R7 read value", 32'(v), 32'(p));
            peek(2'd2, v); chk("R7 cleared", 32'(v), 0);
        end
        pulse_err(4'b0010);
        reg_sel = 2'd2; reg_rd = 1'b1; err_src = 4'b0100;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; err_src = '0;
        chk("R7 read during set", 32'(v), 32'h2);
        peek(2'd2, v); chk("R7 new source kept", 32'(v), 32'h4);
        rd_reg(2'd2, v);

        // R8 mask and enable sweep
        do_reset();
        wr_reg(2'd3, 16'hFFFF);
        peek(2'd3, v); chk("R8 mask width", 32'(v), 32'hF);
        for (int en = 0; en < 2; en++) begin
            for (int m = 0; m < 16; m++) begin
                for (int p = 1; p < 16; p++) begin
                    err_int_en = en[0];
                    wr_reg(2'd3, 16'(m));
                    rd_reg(2'd2, v);
                    step(2);
                    wr_reg(2'd2, 16'h0);
                    pulse_err(ERR_W'(p));
                    step(1);
                    chk("R8 error cause", 32'(irq), 32'(en[0] & ((p & m) != 0)));
                end
            end
        end
        rd_reg(2'd2, v);
        step(2);

        // R9 arming sequence
        do_reset();
        err_int_en = 1; mask_match_en = 1;
        wr_reg(2'd3, 16'h1);
        pulse_err(4'b0001);
        chk("R9 not yet", 32'(irq), 0);
        step(1);
        chk("R9 raised", 32'(irq), 1);
        step(3);
        chk("R9 held", 32'(irq), 1);
        rd_reg(2'd2, v);
        chk("R9 lag on fall", 32'(irq), 1);
        step(1);
        chk("R9 fell", 32'(irq), 0);
        send(23'h345678, 1'b0, 1'b1, 1'b0, 1'b1);
        step(3);
        chk("R9 spent ignores cause", 32'(irq), 0);
        wr_reg(2'd2, 16'hBEEF);
        chk("R9 armed", 32'(irq), 0);
        step(1);
        chk("R9 rearmed raise", 32'(irq), 1);
        rd_reg(2'd0, v);
        chk("R9 lo value", 32'(v), 32'(lo_word(23'h345678)));
        step(1);
        chk("R9 fell after pop", 32'(irq), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule